// File: doc/BRIEF.md
# Memory-Mapped Read Chip-Select Timeout

This block decides when chip select is released on a memory-mapped flash read path. In that mode the serial sequencer keeps reading ahead into a receive FIFO for as long as chip select is held. A bus access starts a command. Later accesses that are flagged as sequential ride on the stream already open, so they need no new instruction or address phase.

If the FIFO fills and the consumer stops popping, a stall counter runs. The period is programmable in 16 bits. When the counter expires, the block pulses a release strobe and drops chip select on the next clock edge. It also sets a sticky timeout flag, which drives an interrupt line when the interrupt enable is set. When the counter is disabled, chip select stays held for as long as the FIFO remains full. After a release, the next access of either kind opens a new command at a 28-bit flash address.

Top module: `mmap_cs_timeout`

## Requirements
- R1: While rst_ni is low, cs_active_o, cmd_start_o, cs_release_o, tmo_flag_o and tmo_irq_o are all 0, and cmd_addr_o is 0.
- R2: With tmo_en_i=1 and chip select held, cs_release_o is 1 combinationally in the (P+1)-th consecutive cycle in which fifo_full_i=1 and fifo_pop_i=0, where P is tmo_period_i. It is 0 in every other cycle.
- R3: A cycle with fifo_pop_i=1, a cycle with fifo_full_i=0, or a new command start restarts the stall count, so a further P+1 stalled cycles are needed before release.
- R4: A period of 0 releases on the first stalled cycle, and a period of 65535 releases on the 65536th stalled cycle.
- R5: With tmo_en_i=0, cs_release_o stays 0 and cs_active_o stays 1 for any number of stalled cycles.
- R6: After a cycle with cs_release_o=1 that starts no command, cs_active_o is 0 from the next clock edge.
- R7: tmo_flag_o goes to 1 on the edge after an expiry and stays 1 until a cycle with tmo_clr_i=1. An expiry in the same cycle as tmo_clr_i=1 leaves the flag set.
- R8: tmo_irq_o equals tmo_flag_o AND tmo_irq_en_i, combinationally.
- R9: A cycle with acc_req_i=1 while chip select is released, or with acc_seq_i=0, starts a command. On the next edge cmd_start_o is 1 for one cycle, cmd_addr_o takes acc_addr_i, and cs_active_o is 1.
- R10: A cycle with acc_req_i=1 and acc_seq_i=1 while chip select is held and not expiring starts no command, and cmd_start_o stays 0.
- R11: A sequential access in the expiry cycle starts a new command. cs_active_o stays 1 and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_en_i | input | 1 | Stall timeout enable |
| tmo_period_i | input | 16 | Stall period P in cycles |
| tmo_irq_en_i | input | 1 | Interrupt enable for the timeout flag |
| tmo_clr_i | input | 1 | Clear strobe for the timeout flag |
| fifo_full_i | input | 1 | Receive FIFO is full |
| fifo_pop_i | input | 1 | Consumer pops one FIFO entry this cycle |
| acc_req_i | input | 1 | Bus read access presented this cycle |
| acc_seq_i | input | 1 | Access follows the previous one sequentially |
| acc_addr_i | input | 28 | Flash address of the access |
| cs_active_o | output | 1 | Chip select held towards the sequencer |
| cmd_start_o | output | 1 | One-cycle strobe: open a new read command |
| cmd_addr_o | output | 28 | Start address of the latest command |
| cs_release_o | output | 1 | Timeout expiry strobe, chip select drops next edge |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_irq_o | output | 1 | Timeout interrupt |

## Verification
The bench drives the release boundary at periods 0, 3 and 65535. An off-by-one counter would release one cycle early or late, and a narrowed counter would wrap before the maximum period. It interrupts a stall with a single pop and with a single non-full cycle. A design that only paused the count instead of reloading it would release too soon. It places a clear and a sequential access in the same cycle as an expiry. There, a wrong priority would lose the flag, or leave a sequential access attached to a stream whose chip select has just dropped. Long stalls with the counter disabled catch any release that does not depend on the enable.

// File: rtl/mmap_cs_pkg.sv
package mmap_cs_pkg;
  localparam int unsigned TMO_W  = 16;
  localparam int unsigned ADDR_W = 28;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_CONT  = 2'd1,
    ACC_START = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mmap_tmo_counter.sv
module mmap_tmo_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic         stall_i,
  input  logic         reload_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         counting;
  logic         at_zero;

  assign counting = en_i & stall_i;
  assign at_zero  = (cnt_q == '0);
  // expiry is independent of reload_i to keep the start path loop-free
  assign expire_o = counting & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!counting || reload_i || at_zero) begin
      cnt_q <= period_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_zero_expires_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stall_i && period_i == '0 && $past(!(en_i && stall_i)))
      |-> expire_o);
endmodule

// File: rtl/mmap_cs_ctrl.sv
module mmap_cs_ctrl
  import mmap_cs_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_req_i,
  input  logic          acc_seq_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          expire_i,
  output logic          start_now_o,
  output logic          cs_active_o,
  output logic          cmd_start_o,
  output logic [AW-1:0] cmd_addr_o
);
  acc_kind_e kind;
  logic      cs_q;
  logic      start_q;
  logic [AW-1:0] addr_q;

  always_comb begin
    kind = ACC_IDLE;
    if (acc_req_i) begin
      // a stream that is expiring this cycle cannot carry a sequential access
      if (cs_q && acc_seq_i && !expire_i) kind = ACC_CONT;
      else                                kind = ACC_START;
    end
  end

  assign start_now_o = (kind == ACC_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b0;
      start_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      start_q <= start_now_o;
      if (start_now_o) begin
        cs_q   <= 1'b1;
        addr_q <= acc_addr_i;
      end else if (expire_i) begin
        cs_q <= 1'b0;
      end
    end
  end

  assign cs_active_o = cs_q;
  assign cmd_start_o = start_q;
  assign cmd_addr_o  = addr_q;

  assert_cs_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !acc_req_i) |=> !cs_active_o);

  assert_start_holds_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> cs_active_o);

  assert_seq_continue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && acc_seq_i && cs_active_o && !expire_i) |=> !cmd_start_o);
endmodule

// File: rtl/mmap_tmo_flag.sv
module mmap_tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/mmap_cs_timeout.sv
module mmap_cs_timeout
  import mmap_cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmo_en_i,
  input  logic [TMO_W-1:0]  tmo_period_i,
  input  logic              tmo_irq_en_i,
  input  logic              tmo_clr_i,
  input  logic              fifo_full_i,
  input  logic              fifo_pop_i,
  input  logic              acc_req_i,
  input  logic              acc_seq_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              cs_active_o,
  output logic              cmd_start_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cs_release_o,
  output logic              tmo_flag_o,
  output logic              tmo_irq_o
);
  logic stall;
  logic expire;
  logic start_now;
  logic cs_active;

  assign stall = fifo_full_i & ~fifo_pop_i & cs_active;

  mmap_tmo_counter #(.W(TMO_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tmo_en_i),
    .period_i (tmo_period_i),
    .stall_i  (stall),
    .reload_i (start_now),
    .expire_o (expire)
  );

  mmap_cs_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_req_i   (acc_req_i),
    .acc_seq_i   (acc_seq_i),
    .acc_addr_i  (acc_addr_i),
    .expire_i    (expire),
    .start_now_o (start_now),
    .cs_active_o (cs_active),
    .cmd_start_o (cmd_start_o),
    .cmd_addr_o  (cmd_addr_o)
  );

  mmap_tmo_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (expire),
    .clr_i    (tmo_clr_i),
    .irq_en_i (tmo_irq_en_i),
    .flag_o   (tmo_flag_o),
    .irq_o    (tmo_irq_o)
  );

  assign cs_active_o  = cs_active;
  assign cs_release_o = expire;

  assert_release_needs_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_release_o |-> (fifo_full_i && !fifo_pop_i && cs_active_o));

  assert_disabled_no_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_en_i |-> !cs_release_o);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_irq_o |-> (tmo_flag_o && tmo_irq_en_i));
endmodule

// File: tb/mmap_cs_timeout_bench.sv
module mmap_cs_timeout_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tmo_en_i = 1'b0, tmo_irq_en_i = 1'b0, tmo_clr_i = 1'b0;
  logic [15:0] tmo_period_i = '0;
  logic        fifo_full_i = 1'b0, fifo_pop_i = 1'b0;
  logic        acc_req_i = 1'b0, acc_seq_i = 1'b0;
  logic [27:0] acc_addr_i = '0;
  logic        cs_active_o, cmd_start_o, cs_release_o, tmo_flag_o, tmo_irq_o;
  logic [27:0] cmd_addr_o;

  always #2 clk = ~clk;

  mmap_cs_timeout u_mmap_cs_timeout (
    .clk_i(clk), .rst_ni(rst_ni), .tmo_en_i(tmo_en_i), .tmo_period_i(tmo_period_i),
    .tmo_irq_en_i(tmo_irq_en_i), .tmo_clr_i(tmo_clr_i), .fifo_full_i(fifo_full_i),
    .fifo_pop_i(fifo_pop_i), .acc_req_i(acc_req_i), .acc_seq_i(acc_seq_i),
    .acc_addr_i(acc_addr_i), .cs_active_o(cs_active_o), .cmd_start_o(cmd_start_o),
    .cmd_addr_o(cmd_addr_o), .cs_release_o(cs_release_o), .tmo_flag_o(tmo_flag_o),
    .tmo_irq_o(tmo_irq_o));

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // configuration applied at the next drive point
  logic        c_en = 1'b0, c_irq = 1'b0;
  logic [15:0] c_per = '0;

  // reference model
  logic        m_cs = 0, m_start = 0, m_flag = 0;
  logic [27:0] m_addr = '0;
  int unsigned m_run = 0;
  logic        last_rel;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_expire(logic full, logic pop);
    return full && !pop && m_cs && c_en && (m_run == c_per);
  endfunction

  function automatic logic f_start(logic req, logic seq, logic ex);
    return req && (!m_cs || !seq || ex);
  endfunction

  task automatic cyc(logic full, logic pop, logic req, logic seq, logic [27:0] addr, logic clr);
    logic ex, st, stl;
    @(negedge clk);
    chk("R6/R9 cs_active_o", cs_active_o, m_cs);
    chk("R9/R10 cmd_start_o", cmd_start_o, m_start);
    chk("R9 cmd_addr_o", cmd_addr_o, m_addr);
    chk("R7 tmo_flag_o", tmo_flag_o, m_flag);
    tmo_en_i = c_en; tmo_irq_en_i = c_irq; tmo_period_i = c_per;
    fifo_full_i = full; fifo_pop_i = pop; acc_req_i = req; acc_seq_i = seq;
    acc_addr_i = addr; tmo_clr_i = clr;
    #1;
    stl = full && !pop && m_cs && c_en;
    ex  = f_expire(full, pop);
    st  = f_start(req, seq, ex);
    chk("R2 cs_release_o", cs_release_o, ex);
    chk("R8 tmo_irq_o", tmo_irq_o, m_flag & c_irq);
    last_rel = cs_release_o;
    m_run   = (stl && !st && !ex) ? m_run + 1 : 0;
    m_start = st;
    if (st) begin m_cs = 1'b1; m_addr = addr; end
    else if (ex) m_cs = 1'b0;
    if (ex) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
  endtask

  task automatic open_cmd(logic [27:0] a);
    cyc(0, 0, 1, 0, a, 0);
    cyc(0, 0, 0, 0, '0, 0);
  endtask

  // returns index of the first stalled cycle with a release, or -1
  task automatic stall_run(int n, output int rel_at);
    rel_at = -1;
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, '0, 0);
      if (last_rel && rel_at < 0) rel_at = i;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int r;
    // R1 reset state
    #3;
    chk("R1 cs_active_o", cs_active_o, 0);
    chk("R1 cmd_start_o", cmd_start_o, 0);
    chk("R1 cs_release_o", cs_release_o, 0);
    chk("R1 tmo_flag_o", tmo_flag_o, 0);
    chk("R1 tmo_irq_o", tmo_irq_o, 0);
    chk("R1 cmd_addr_o", cmd_addr_o, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 period 3
    c_en = 1; c_per = 16'd3; c_irq = 1;
    open_cmd(28'h0123456);
    stall_run(6, r);
    chk("R2 release index", r, 3);
    chk("R6 cs dropped", cs_active_o, 0);

    // R7 clear, then clear colliding with expiry
    cyc(0, 0, 0, 0, '0, 1);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R7 cleared", tmo_flag_o, 0);
    c_per = 16'd0;
    open_cmd(28'h0000040);
    cyc(1, 0, 0, 0, '0, 1);
    chk("R7 expiry with clear", last_rel, 1);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R7 set wins over clear", tmo_flag_o, 1);
    c_irq = 0;
    cyc(0, 0, 0, 0, '0, 0);
    chk("R8 irq masked", tmo_irq_o, 0);
    cyc(0, 0, 0, 0, '0, 1);

    // R4 period 0
    open_cmd(28'h0000100);
    stall_run(2, r);
    chk("R4 period 0 index", r, 0);

    // R3 pop and non-full restart the count
    c_per = 16'd3;
    open_cmd(28'h0000200);
    stall_run(2, r);
    cyc(1, 1, 0, 0, '0, 0);
    stall_run(6, r);
    chk("R3 pop reload index", r, 3);
    open_cmd(28'h0000300);
    stall_run(3, r);
    cyc(0, 0, 0, 0, '0, 0);
    stall_run(6, r);
    chk("R3 not-full reload index", r, 3);

    // R10 sequential continues, R9 non-sequential restarts while held
    open_cmd(28'h0000400);
    cyc(0, 0, 1, 1, 28'h0000401, 0);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R10 no start on seq", cmd_start_o, 0);
    cyc(0, 0, 1, 0, 28'hABCDEF0, 0);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R9 restart addr", cmd_addr_o, 28'hABCDEF0);

    // R11 sequential access in the expiry cycle
    stall_run(3, r);
    cyc(1, 0, 1, 1, 28'h0000500, 0);
    chk("R11 expiry seen", last_rel, 1);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R11 start", cmd_start_o, 1);
    chk("R11 cs held", cs_active_o, 1);
    chk("R11 flag", tmo_flag_o, 1);

    // R9 sequential access after release starts a command
    stall_run(5, r);
    cyc(0, 0, 1, 1, 28'h0000600, 0);
    cyc(0, 0, 0, 0, '0, 0);
    chk("R9 seq after release", cmd_start_o, 1);

    // R5 disabled: held forever
    c_en = 0;
    stall_run(600, r);
    chk("R5 no release", r, -1);
    chk("R5 cs held", cs_active_o, 1);

    // R4 maximum period
    c_en = 1; c_per = 16'hFFFF;
    cyc(0, 0, 0, 0, '0, 0);
    stall_run(65538, r);
    chk("R4 period max index", r, 65535);

    // constrained random segments
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 40; s++) begin
      c_per = 16'($urandom_range(0, 6));
      c_en  = ($urandom_range(0, 3) != 0);
      c_irq = $urandom_range(0, 1);
      cyc(0, 0, 0, 0, '0, 0);
      for (int k = 0; k < 100; k++)
        cyc(($urandom_range(0, 9) < 8), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 9) == 0), $urandom_range(0, 1),
            28'($urandom), ($urandom_range(0, 15) == 0));
    end
    cyc(0, 0, 0, 0, '0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule